// File: doc/BRIEF.md
# Ping-Pong Symbol Buffer Controller for Interleaving

This block sits between a bit source and a bit sink and reorders data one OFDM symbol at a time. It holds two symbol-sized banks. The banks take turns: one bank is filled with the words of the incoming symbol while the other bank, which already holds the whole previous symbol, is emitted. Each word is `DATA_W` bits wide, six by default. A symbol is `SYM_WORDS` words long.

The permutation itself is computed outside the block. The controller presents a symbol-relative index on `agu_idx_o`, and an external address generator returns the permuted slot on `agu_addr_i` in the same cycle. One generator is enough for both directions, because the control logic decides which side uses the permuted address:

- In interleave mode, words are stored at the permuted slots and read back in ascending slot order.
- In deinterleave mode, words are stored in ascending order and read from the permuted slots.

A control state machine steps through four states: idle, first fill, concurrent stream, and read-only drain. The mode is taken only at a symbol boundary. A change of mode waits until the buffer has emptied.

Top module: `pingpong_ileave_buf`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: With mode_i = 0 (interleave), input word k of a symbol (k counted from 0) is stored at the slot the generator returns for index k, and the symbol is emitted in ascending slot order 0 .. SYM_WORDS-1.
- R3: With mode_i = 1 (deinterleave), input word k is stored at slot k, and output word j is taken from the slot the generator returns for index j.
- R4: With input always valid and out_ready held at 1, every word of each following symbol is accepted with in_ready high, while the previous symbol is read out in parallel at one word per cycle.
- R5: out_valid is high only while a bank holding a fully written symbol is being read. It first rises in the cycle after the last word of the first symbol is accepted.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_valid and out_data hold their values.
- R7: agu_idx_o carries the index within the symbol for the side that uses permuted addressing: the write side for mode 0, the read side for mode 1. agu_req_o is 1 exactly in the cycles in which that side transfers a word.
- R8: A change of mode_i after the first word of a symbol has been accepted has no effect on that symbol.
- R9: When mode_i differs from the mode in use at a symbol boundary, the first word of the new symbol is not accepted until every stored word has been emitted. That symbol is then handled in the new mode.
- R10: out_last is 1 together with the last word of every symbol, and 0 for all other output words.
- R11: Gaps in in_valid and random out_ready still give complete, correctly ordered symbols. Once everything has been read and no input is pending, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 selects interleaving, 1 selects deinterleaving |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Sink accepts the output word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Marks the final word of a symbol |
| agu_idx_o | output | $clog2(SYM_WORDS) | Index within the symbol sent to the address generator |
| agu_req_o | output | 1 | The permuted side moves a word this cycle |
| agu_addr_i | input | $clog2(SYM_WORDS) | Permuted slot returned by the address generator |

## Verification
The bench builds the block with DATA_W = 6 and SYM_WORDS = 8. Eight-word symbols make bank swaps, fill-to-stream transitions and mode handovers frequent, so many of them occur in a few hundred cycles. The bench supplies its own generator, the bijection 3k+5 mod 8. Because this is not a simple reversal, wrongly routed write and read addresses show up as misordered data. Its small index width also lets out_last and counter wrap faults appear on every symbol.

// File: rtl/ppib_pkg.sv
package ppib_pkg;

  // Control states of the two-bank buffer.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // both banks empty
    ST_FILL   = 2'd1,  // writing a symbol, nothing to read
    ST_STREAM = 2'd2,  // reading a full bank while the other is being written
    ST_DRAIN  = 2'd3   // reading a full bank, next symbol not yet started
  } ppib_state_e;

endpackage

// File: rtl/ppib_ctrl.sv
module ppib_ctrl
  import ppib_pkg::*;
#(
  parameter int SYM_WORDS = 48,
  localparam int AW = $clog2(SYM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic          w_fire,
  output logic          r_fire,
  output logic [AW-1:0] wcnt,
  output logic [AW-1:0] rcnt,
  output logic          wsel,
  output logic          mode_sel
);

  localparam logic [AW-1:0] LAST = AW'(SYM_WORDS - 1);

  ppib_state_e   st_q, st_n;
  logic [AW-1:0] wcnt_q, wcnt_n;
  logic [AW-1:0] rcnt_q, rcnt_n;
  logic          wsel_q, wsel_n;
  logic          mode_q, mode_n;
  logic          wr_last, rd_last;
  logic          step_en, mode_en;
  logic          mode_match;

  assign wr_last    = (wcnt_q == LAST);
  assign rd_last    = (rcnt_q == LAST);
  assign mode_match = (mode_i == mode_q);

  // Handshake generation
  assign out_valid = (st_q == ST_STREAM) || (st_q == ST_DRAIN);

  always_comb begin
    unique case (st_q)
      ST_IDLE:   in_ready = 1'b1;
      ST_FILL:   in_ready = 1'b1;
      ST_STREAM: in_ready = out_ready;               // write tracks read
      ST_DRAIN:  in_ready = out_ready && mode_match; // boundary: gate mode change
      default:   in_ready = 1'b0;
    endcase
  end

  assign w_fire   = in_valid && in_ready;
  assign r_fire   = out_valid && out_ready;
  assign out_last = out_valid && rd_last;

  // Mode in force for the side that is active this cycle
  assign mode_sel = (st_q == ST_IDLE) ? mode_i : mode_q;

  // Next-state logic
  always_comb begin
    st_n   = st_q;
    wcnt_n = wcnt_q;
    rcnt_n = rcnt_q;
    wsel_n = wsel_q;
    mode_n = mode_q;

    if (w_fire) wcnt_n = wr_last ? '0 : wcnt_q + 1'b1;
    if (r_fire) rcnt_n = rd_last ? '0 : rcnt_q + 1'b1;
    if (w_fire && wr_last) wsel_n = ~wsel_q;

    unique case (st_q)
      ST_IDLE: begin
        if (w_fire) begin
          st_n   = ST_FILL;
          mode_n = mode_i;
        end
      end
      ST_FILL: begin
        if (w_fire && wr_last) st_n = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (r_fire && rd_last)
          st_n = w_fire ? ST_FILL : ST_IDLE;
        else if (w_fire)
          st_n = ST_STREAM;
      end
      ST_STREAM: begin
        if (r_fire && rd_last)
          st_n = (w_fire && wr_last) ? ST_DRAIN : ST_FILL;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign step_en = w_fire || r_fire;
  assign mode_en = (st_q == ST_IDLE) && w_fire;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      rcnt_q <= '0;
      wsel_q <= 1'b0;
    end else if (step_en) begin
      st_q   <= st_n;
      wcnt_q <= wcnt_n;
      rcnt_q <= rcnt_n;
      wsel_q <= wsel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (mode_en) begin
      mode_q <= mode_n;
    end
  end

  assign wcnt = wcnt_q;
  assign rcnt = rcnt_q;
  assign wsel = wsel_q;

endmodule

// File: rtl/ppib_addr_route.sv
module ppib_addr_route #(
  parameter int SYM_WORDS = 48,
  localparam int AW = $clog2(SYM_WORDS)
) (
  input  logic          mode_sel,   // 0: write permuted, 1: read permuted
  input  logic          w_fire,
  input  logic          r_fire,
  input  logic [AW-1:0] wcnt,
  input  logic [AW-1:0] rcnt,
  input  logic [AW-1:0] agu_addr_i,
  output logic [AW-1:0] agu_idx_o,
  output logic          agu_req_o,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr
);

  // A single generator serves whichever side is permuted; swapping the
  // request between sides turns the interleaver into the deinterleaver.
  always_comb begin
    if (mode_sel) begin
      agu_idx_o = rcnt;
      agu_req_o = r_fire;
      waddr     = wcnt;
      raddr     = agu_addr_i;
    end else begin
      agu_idx_o = wcnt;
      agu_req_o = w_fire;
      waddr     = agu_addr_i;
      raddr     = rcnt;
    end
  end

endmodule

// File: rtl/ppib_banks.sv
module ppib_banks #(
  parameter int DATA_W    = 6,
  parameter int SYM_WORDS = 48,
  localparam int AW = $clog2(SYM_WORDS),
  localparam int NB = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wsel,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_word [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DATA_W-1:0] mem [SYM_WORDS];
    logic              bank_we;

    assign bank_we = we && (wsel == 1'(b));

    always_ff @(posedge clk) begin
      if (bank_we) mem[waddr] <= wdata;
    end

    assign rd_word[b] = mem[raddr];
  end

  // The read bank is always the one not being written.
  assign rdata = wsel ? rd_word[0] : rd_word[1];

endmodule

// File: rtl/pingpong_ileave_buf.sv
module pingpong_ileave_buf #(
  parameter int DATA_W    = 6,
  parameter int SYM_WORDS = 48,
  localparam int AW = $clog2(SYM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [AW-1:0]     agu_idx_o,
  output logic              agu_req_o,
  input  logic [AW-1:0]     agu_addr_i
);

  logic          w_fire, r_fire;
  logic [AW-1:0] wcnt, rcnt;
  logic [AW-1:0] waddr, raddr;
  logic          wsel;
  logic          mode_sel;

  ppib_ctrl #(.SYM_WORDS(SYM_WORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .w_fire    (w_fire),
    .r_fire    (r_fire),
    .wcnt      (wcnt),
    .rcnt      (rcnt),
    .wsel      (wsel),
    .mode_sel  (mode_sel)
  );

  ppib_addr_route #(.SYM_WORDS(SYM_WORDS)) u_route (
    .mode_sel   (mode_sel),
    .w_fire     (w_fire),
    .r_fire     (r_fire),
    .wcnt       (wcnt),
    .rcnt       (rcnt),
    .agu_addr_i (agu_addr_i),
    .agu_idx_o  (agu_idx_o),
    .agu_req_o  (agu_req_o),
    .waddr      (waddr),
    .raddr      (raddr)
  );

  ppib_banks #(.DATA_W(DATA_W), .SYM_WORDS(SYM_WORDS)) u_banks (
    .clk   (clk),
    .we    (w_fire),
    .wsel  (wsel),
    .waddr (waddr),
    .wdata (in_data),
    .raddr (raddr),
    .rdata (out_data)
  );

endmodule

// File: rtl/ppib_checker.sv
module ppib_checker #(
  parameter int SYM_WORDS = 48,
  localparam int AW = $clog2(SYM_WORDS),
  localparam int OW = $clog2(2 * SYM_WORDS + 1) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_last,
  input logic agu_req_o
);

  logic          in_beat, out_beat;
  logic [OW-1:0] occ_q;
  logic [AW-1:0] rk_q;

  assign in_beat  = in_valid && in_ready;
  assign out_beat = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      rk_q  <= '0;
    end else begin
      occ_q <= occ_q + OW'(in_beat) - OW'(out_beat);
      if (out_beat) rk_q <= (rk_q == AW'(SYM_WORDS - 1)) ? '0 : rk_q + 1'b1;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R6
  stall_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R10
  last_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_beat && out_last) |=> !out_last);

  // R5
  full_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(occ_q) + int'(rk_q) >= SYM_WORDS));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_q) <= 2 * SYM_WORDS);

  // R7
  agu_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agu_req_o |-> (in_beat || out_beat));

endmodule

bind pingpong_ileave_buf ppib_checker #(.SYM_WORDS(SYM_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .agu_req_o (agu_req_o)
);

// File: tb/sim_pingpong_ileave_buf.sv
module sim_pingpong_ileave_buf;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 6;
  localparam int SYM = 8;
  localparam int AW  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_i;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  in_data;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_data;
  logic          out_last;
  logic [AW-1:0] agu_idx;
  logic          agu_req;
  logic [AW-1:0] agu_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pingpong_ileave_buf #(.DATA_W(W), .SYM_WORDS(SYM)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .agu_idx_o(agu_idx), .agu_req_o(agu_req),
    .agu_addr_i(agu_addr)
  );

  // Bench-side address generator: bijection 3k+5 mod 8
  assign agu_addr = AW'((int'(agu_idx) * 3 + 5) % SYM);

  int           checks = 0;
  int           errors = 0;
  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  bit           mq [$];
  int           wk = 0;
  int           rk = 0;
  bit           mon_on = 1'b0;
  bit           hold_val = 1'b0;
  bit           bp_rand = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int perm(input int k);
    return (3 * k + 5) % SYM;
  endfunction

  function automatic logic [W-1:0] word(input int seed, input int k);
    return W'((seed * 13 + k * 5 + 1) % 64);
  endfunction

  // Driver: pushes the expected symbol, then offers its words
  task automatic send_symbol(input bit m, input int seed, input string tag,
                             input bit check_fill, input bit gaps,
                             input int flip_at, input bit idle_first,
                             output int stalls);
    logic [W-1:0] o [SYM];
    stalls = 0;
    for (int k = 0; k < SYM; k++) begin
      if (m == 1'b0) o[perm(k)] = word(seed, k);
      else           o[k]       = word(seed, perm(k));
    end
    for (int j = 0; j < SYM; j++) begin
      exp_q.push_back(o[j]);
      tag_q.push_back(tag);
    end
    mq.push_back(m);
    mode_i = m;
    for (int k = 0; k < SYM; k++) begin
      if (gaps && (k % 3 == 1)) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      if (k == flip_at) mode_i = ~m;
      in_valid = 1'b1;
      in_data  = word(seed, k);
      forever begin
        @(negedge clk);
        if (check_fill) chk(out_valid == 1'b0, "R5", int'(out_valid), 0);
        if (in_ready) break;
        stalls++;
      end
      if (idle_first && k == 0) chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  // Output-ready generator
  initial begin
    forever begin
      @(posedge clk); #1;
      if (bp_rand) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0] | lfsr[3];
      end else begin
        out_ready = hold_val;
      end
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      bit           em;
      logic [W-1:0] e;
      string        t;
      em = (mq.size() > 0) ? mq[0] : mode_i;
      if (em) begin
        chk(agu_req == (out_valid && out_ready), "R7", int'(agu_req), int'(out_valid && out_ready));
        if (agu_req) chk(int'(agu_idx) == rk, "R7", int'(agu_idx), rk);
      end else begin
        chk(agu_req == (in_valid && in_ready), "R7", int'(agu_req), int'(in_valid && in_ready));
        if (agu_req) chk(int'(agu_idx) == wk, "R7", int'(agu_idx), wk);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", int'(out_data), -1);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, int'(out_data), int'(e));
        end
        chk(out_last == (rk == SYM - 1), "R10", int'(out_last), int'(rk == SYM - 1));
        if (rk == SYM - 1) begin
          rk = 0;
          if (mq.size() > 0) void'(mq.pop_front());
        end else begin
          rk++;
        end
      end
      if (in_valid && in_ready) wk = (wk == SYM - 1) ? 0 : wk + 1;
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int           st;
    logic [W-1:0] held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    mode_i   = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_last == 1'b0, "R1", int'(out_last), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    @(posedge clk); #1;
    mon_on = 1'b1;

    // R5: first fill, output must stay invalid until the bank is full
    send_symbol(1'b0, 1, "R2", 1'b1, 1'b0, -1, 1'b0, st);
    chk(out_valid == 1'b1, "R5", int'(out_valid), 1);

    // R6: output stalled, input must be refused and data held
    @(negedge clk);
    held = out_data;
    in_valid = 1'b1;
    in_data  = 6'h2a;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R6", int'(in_ready), 0);
      chk(out_valid == 1'b1, "R6", int'(out_valid), 1);
      chk(out_data == held, "R6", int'(out_data), int'(held));
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    hold_val = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // R4: back-to-back symbols, no input stall
    for (int s = 2; s <= 4; s++) begin
      send_symbol(1'b0, s, "R4", 1'b0, 1'b0, -1, 1'b0, st);
      chk(st == 0, "R4", st, 0);
    end

    // R8: mode flipped mid-symbol is ignored (data still interleaved)
    send_symbol(1'b0, 5, "R8", 1'b0, 1'b0, 3, 1'b0, st);
    chk(st == 0, "R8", st, 0);

    // R9: switch to deinterleave at the boundary, must wait for drain
    send_symbol(1'b1, 6, "R9", 1'b0, 1'b0, -1, 1'b1, st);
    chk(st > 0, "R9", st, 1);

    // R3: deinterleave, continuous
    send_symbol(1'b1, 7, "R3", 1'b0, 1'b0, -1, 1'b0, st);
    chk(st == 0, "R3", st, 0);

    // R11: gaps on input and random output backpressure, both modes
    bp_rand = 1'b1;
    send_symbol(1'b1, 8,  "R11", 1'b0, 1'b1, -1, 1'b0, st);
    send_symbol(1'b1, 9,  "R11", 1'b0, 1'b1, -1, 1'b0, st);
    send_symbol(1'b0, 10, "R11", 1'b0, 1'b1, -1, 1'b0, st);
    send_symbol(1'b0, 11, "R11", 1'b0, 1'b0, -1, 1'b0, st);
    send_symbol(1'b0, 12, "R11", 1'b0, 1'b1, -1, 1'b0, st);

    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11", int'(in_ready), 1);
    chk(mq.size() == 0, "R11", mq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule